// File: doc/BRIEF.md
# Blocking-Budget Output Arbiter

This block is the arbitration stage in front of one output port of an on-chip network router. It chooses between one queue of guaranteed-latency (GL) traffic and several queues of best-effort (BE) traffic. By default best-effort traffic goes first, so it gets low latency. Guaranteed traffic is only held back as far as its deadline allows.

The allowance travels with each GL packet as a blocking budget in the low bits of its head flit. The arbiter keeps the live budget of the GL packet at the head of the queue and lowers it by one for every BE flit that crosses the port while that packet waits. When the budget reaches zero the port enters its critical state, and the GL packet is served before any BE queue. The head flit leaves with the reduced budget written back into it, so the next router sees only the blocking that remains.

Arbitration is wormhole: a granted packet keeps the port until its tail flit has gone. A grant means the flit on that queue is offered at the output, and the flit moves on any cycle where the grant and `out_ready` are both high. The budget can be charged per flit, which is the default, or per packet.

Top module: `bcarb_port_arbiter`

## Requirements
- R1: After reset no grant and no `out_valid` are raised while no queue requests, and the first BE round-robin choice is queue 0.
- R2: When the port is free and the waiting GL head packet has a nonzero budget, a requesting BE queue is granted ahead of it.
- R3: While a GL head flit waits, its budget drops by one for each BE flit that is actually transferred. A cycle with `out_ready` low charges nothing.
- R4: When the port is free and the waiting GL head packet has a budget of zero, GL is granted and no BE queue is.
- R5: A GL packet with a nonzero budget is granted when no BE queue requests, and its budget is forwarded without a decrement.
- R6: The budget occupies bits [CNT_W-1:0] of a head flit. The outgoing GL head flit carries the live budget in that field with its other bits unchanged. GL non-head flits pass through unchanged.
- R7: The budget saturates at zero. Further BE transfers leave it at zero.
- R8: Once a head flit that is not also a tail has been transferred, the port stays granted to that queue until its tail flit transfers.
- R9: BE queues are served round-robin. After BE queue i starts a packet, the search for the next choice begins at queue i+1, wrapping around.
- R10: At most one grant is raised at a time, only to a queue whose valid is high, and `out_valid` is high exactly when a grant is raised.
- R11: After a critical GL packet has left, the next GL packet starts from the budget in its own header, so the port returns to preferring BE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gl_valid | input | 1 | GL queue has a flit |
| gl_head | input | 1 | GL flit is a head flit |
| gl_tail | input | 1 | GL flit is a tail flit |
| gl_data | input | DATA_W | GL flit payload; budget in low CNT_W bits of a head flit |
| gl_grant | output | 1 | GL flit is offered at the output |
| be_valid | input | NUM_BE | Per-BE-queue flit present |
| be_head | input | NUM_BE | Per-BE-queue head marker |
| be_tail | input | NUM_BE | Per-BE-queue tail marker |
| be_data | input | NUM_BE x DATA_W | Per-BE-queue flit payload |
| be_grant | output | NUM_BE | One-hot BE grant |
| out_ready | input | 1 | Downstream accepts a flit this cycle |
| out_valid | output | 1 | Output flit valid |
| out_head | output | 1 | Output flit is a head |
| out_tail | output | 1 | Output flit is a tail |
| out_data | output | DATA_W | Output flit, budget rewritten on GL heads |

## Verification
The bench replays the six-cycle exchange of a GL queue against one BE queue and checks the grant and forwarded budget at each step. If the budget were decremented while no BE traffic was present, or never decremented, GL would be granted in the wrong cycle and the forwarded value would differ. A stalled output is tested for spurious charging: a design that charged on offers instead of transfers would let GL win during the stall. A GL packet whose budget runs out during a long BE packet is checked in two ways. A design that dropped the wormhole lock would cut into the BE packet. A design that wrapped the counter past zero would keep GL waiting behind the next BE packet. Round-robin order starting from queue 0, pass-through of GL body flits and a fresh budget for a new GL packet are checked as well.

// File: rtl/bcarb_pkg.sv
package bcarb_pkg;

   // Unit in which the blocking budget is charged.
   typedef enum logic {
      BC_PER_FLIT   = 1'b0,
      BC_PER_PACKET = 1'b1
   } bc_unit_e;

   // Source currently driving the output port.
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_GL   = 2'd1,
      SRC_BE   = 2'd2
   } src_e;

endpackage

// File: rtl/bcarb_bc_tracker.sv
// Holds the live blocking budget of the GL packet at the head of its queue.
module bcarb_bc_tracker #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] hdr_bc,
   input  logic             charge,
   input  logic             release_hd,
   output logic [CNT_W-1:0] live_bc
);

   logic             held_q;
   logic [CNT_W-1:0] bc_q;

   assign live_bc = held_q ? bc_q : hdr_bc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         bc_q   <= '0;
      end else if (release_hd) begin
         held_q <= 1'b0;
      end else if (charge) begin
         held_q <= 1'b1;
         bc_q   <= (live_bc == '0) ? '0 : live_bc - 1'b1;
      end
   end

endmodule

// File: rtl/bcarb_rr_pick.sv
// Round-robin choice among the best-effort queues.
module bcarb_rr_pick #(
   parameter int N = 4,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic [IW-1:0] pick_idx,
   output logic          pick_any
);

   logic [IW-1:0] ptr_q;

   always_comb begin
      pick_any = 1'b0;
      pick_idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         int s;
         s = int'(ptr_q) + k;
         if (s >= N) s = s - N;
         if (req[s]) begin
            pick_any = 1'b1;
            pick_idx = IW'(s);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv) begin
         ptr_q <= (int'(pick_idx) == N - 1) ? '0 : pick_idx + 1'b1;
      end
   end

endmodule

// File: rtl/bcarb_wormhole_lock.sv
// Keeps the output owned by a packet from its head to its tail flit.
module bcarb_wormhole_lock #(
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          xfer,
   input  logic          head,
   input  logic          tail,
   input  logic          is_gl,
   input  logic [IW-1:0] idx,
   output logic          busy,
   output logic          own_gl,
   output logic [IW-1:0] own_idx
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         own_gl  <= 1'b0;
         own_idx <= '0;
      end else if (xfer) begin
         if (tail) begin
            busy <= 1'b0;
         end else if (head) begin
            busy    <= 1'b1;
            own_gl  <= is_gl;
            own_idx <= idx;
         end
      end
   end

endmodule

// File: rtl/bcarb_port_arbiter.sv
module bcarb_port_arbiter #(
   parameter int                  DATA_W  = 16,
   parameter int                  CNT_W   = 8,
   parameter int                  NUM_BE  = 4,
   parameter bcarb_pkg::bc_unit_e BC_UNIT = bcarb_pkg::BC_PER_FLIT
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           gl_valid,
   input  logic                           gl_head,
   input  logic                           gl_tail,
   input  logic [DATA_W-1:0]              gl_data,
   output logic                           gl_grant,
   input  logic [NUM_BE-1:0]              be_valid,
   input  logic [NUM_BE-1:0]              be_head,
   input  logic [NUM_BE-1:0]              be_tail,
   input  logic [NUM_BE-1:0][DATA_W-1:0]  be_data,
   output logic [NUM_BE-1:0]              be_grant,
   input  logic                           out_ready,
   output logic                           out_valid,
   output logic                           out_head,
   output logic                           out_tail,
   output logic [DATA_W-1:0]              out_data
);
   import bcarb_pkg::*;

   localparam int IW = $clog2(NUM_BE);
   localparam logic [DATA_W-1:0] BC_MASK = {DATA_W{1'b1}} >> (DATA_W - CNT_W);

   if (NUM_BE < 2) begin : g_bad_nbe
      $error("NUM_BE must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cw
      $error("CNT_W must lie in 1..DATA_W");
   end

   logic             gl_wait, crit;
   logic [CNT_W-1:0] eff_bc;
   logic [IW-1:0]    rr_idx, sel_idx, lk_idx;
   logic             rr_any, lk_busy, lk_gl;
   logic             be_xfer, gl_xfer, dec_evt;
   src_e             src;

   assign gl_wait = gl_valid & gl_head;
   assign crit    = gl_wait & (eff_bc == '0);

   always_comb begin
      src     = SRC_NONE;
      sel_idx = rr_idx;
      if (lk_busy) begin
         if (lk_gl) begin
            src = SRC_GL;
         end else begin
            src     = SRC_BE;
            sel_idx = lk_idx;
         end
      end else if (crit) begin
         src = SRC_GL;
      end else if (rr_any) begin
         src = SRC_BE;
      end else if (gl_valid) begin
         src = SRC_GL;
      end
   end

   always_comb begin
      gl_grant  = (src == SRC_GL) & gl_valid;
      be_grant  = '0;
      out_valid = 1'b0;
      out_head  = 1'b0;
      out_tail  = 1'b0;
      out_data  = '0;
      if (src == SRC_GL) begin
         out_valid = gl_valid;
         out_head  = gl_head;
         out_tail  = gl_tail;
         out_data  = gl_head ? ((gl_data & ~BC_MASK) | DATA_W'(eff_bc)) : gl_data;
      end else if (src == SRC_BE) begin
         be_grant[sel_idx] = be_valid[sel_idx];
         out_valid = be_valid[sel_idx];
         out_head  = be_head[sel_idx];
         out_tail  = be_tail[sel_idx];
         out_data  = be_data[sel_idx];
      end
   end

   assign be_xfer = (|be_grant) & out_ready;
   assign gl_xfer = gl_grant & out_ready;

   if (BC_UNIT == BC_PER_FLIT) begin : g_flit_charge
      assign dec_evt = be_xfer;
   end else begin : g_pkt_charge
      assign dec_evt = be_xfer & out_head;
   end

   bcarb_bc_tracker #(.CNT_W(CNT_W)) u_bc (
      .clk       (clk),
      .rst_n     (rst_n),
      .hdr_bc    (gl_data[CNT_W-1:0]),
      .charge    (dec_evt & gl_wait),
      .release_hd(gl_xfer & gl_head),
      .live_bc   (eff_bc)
   );

   bcarb_rr_pick #(.N(NUM_BE)) u_rr (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (be_valid),
      .adv     (be_xfer & out_head & ~lk_busy),
      .pick_idx(rr_idx),
      .pick_any(rr_any)
   );

   bcarb_wormhole_lock #(.IW(IW)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .xfer   (out_valid & out_ready),
      .head   (out_head),
      .tail   (out_tail),
      .is_gl  (src == SRC_GL),
      .idx    (sel_idx),
      .busy   (lk_busy),
      .own_gl (lk_gl),
      .own_idx(lk_idx)
   );

endmodule

// File: rtl/bcarb_port_arbiter_chk.sv
module bcarb_port_arbiter_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8,
   parameter int NUM_BE = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gl_valid,
   input logic              gl_head,
   input logic              gl_tail,
   input logic [DATA_W-1:0] gl_data,
   input logic              gl_grant,
   input logic [NUM_BE-1:0] be_valid,
   input logic [NUM_BE-1:0] be_tail,
   input logic [NUM_BE-1:0] be_grant,
   input logic              out_ready,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic [CNT_W-1:0]  eff_bc,
   input logic              lk_busy
);

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gl_grant, be_grant}) && (out_valid == (gl_grant || (|be_grant)))) // R10
      else $error("more than one grant or out_valid mismatch");

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((be_grant & ~be_valid) == '0) && !(gl_grant && !gl_valid)) // R10
      else $error("grant to idle queue");

   AST_LOCK_BE: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(be_grant & ~be_tail)) && out_ready) |=> !gl_grant) // R8
      else $error("GL cut into a BE packet");

   AST_LOCK_GL: assert property (@(posedge clk) disable iff (!rst_n)
      (gl_grant && !gl_tail && out_ready) |=> (be_grant == '0)) // R8
      else $error("BE cut into a GL packet");

   AST_CRIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (gl_valid && gl_head && eff_bc == '0 && !lk_busy) |-> (gl_grant && be_grant == '0)) // R4
      else $error("critical GL not served");

   AST_BC_NOT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (gl_grant && gl_head) |-> (out_data[CNT_W-1:0] <= gl_data[CNT_W-1:0])) // R3
      else $error("forwarded budget above header budget");

   AST_BODY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (gl_grant && !gl_head) |-> (out_data == gl_data)) // R6
      else $error("GL body flit altered");

endmodule

bind bcarb_port_arbiter bcarb_port_arbiter_chk #(
   .DATA_W(DATA_W),
   .CNT_W (CNT_W),
   .NUM_BE(NUM_BE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .gl_valid (gl_valid),
   .gl_head  (gl_head),
   .gl_tail  (gl_tail),
   .gl_data  (gl_data),
   .gl_grant (gl_grant),
   .be_valid (be_valid),
   .be_tail  (be_tail),
   .be_grant (be_grant),
   .out_ready(out_ready),
   .out_valid(out_valid),
   .out_data (out_data),
   .eff_bc   (eff_bc),
   .lk_busy  (lk_busy)
);

// File: tb/test_bcarb_port_arbiter.sv
module test_bcarb_port_arbiter;

   localparam int CLK_P  = 10;
   localparam int DW     = 16;
   localparam int NBE    = 4;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic                    gl_valid, gl_head, gl_tail;
   logic [DW-1:0]           gl_data;
   logic                    gl_grant;
   logic [NBE-1:0]          be_valid, be_head, be_tail;
   logic [NBE-1:0][DW-1:0]  be_data;
   logic [NBE-1:0]          be_grant;
   logic                    out_ready;
   logic                    out_valid, out_head, out_tail;
   logic [DW-1:0]           out_data;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   bcarb_port_arbiter i_bcarb_port_arbiter (
      .clk(clk), .rst_n(rst_n),
      .gl_valid(gl_valid), .gl_head(gl_head), .gl_tail(gl_tail),
      .gl_data(gl_data), .gl_grant(gl_grant),
      .be_valid(be_valid), .be_head(be_head), .be_tail(be_tail),
      .be_data(be_data), .be_grant(be_grant),
      .out_ready(out_ready), .out_valid(out_valid), .out_head(out_head),
      .out_tail(out_tail), .out_data(out_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic clr_in();
      gl_valid = 0; gl_head = 0; gl_tail = 0; gl_data = '0;
      be_valid = '0; be_head = '0; be_tail = '0; be_data = '0;
   endtask

   task automatic set_gl(input logic h, input logic t, input logic [DW-1:0] d);
      gl_valid = 1; gl_head = h; gl_tail = t; gl_data = d;
   endtask

   task automatic set_be(input int i, input logic h, input logic t);
      be_valid[i] = 1; be_head[i] = h; be_tail[i] = t;
      be_data[i]  = 16'hB000 | DW'(i << 8);
   endtask

   task automatic next_cycle();
      @(negedge clk);
      clr_in();
   endtask

   task automatic t_reset();
      next_cycle();
      #1;
      chk("R1 out_valid idle", out_valid, 0);
      chk("R10 no grant idle", {gl_grant, be_grant}, 0);
   endtask

   task automatic t_round_robin();
      for (int k = 0; k < 5; k++) begin
         next_cycle();
         for (int i = 0; i < NBE; i++) set_be(i, 1, 1);
         #1;
         chk(k == 0 ? "R1 first BE pick" : "R9 rr order", be_grant, 32'(1 << (k % NBE)));
         chk("R10 out_valid with grant", out_valid, 1);
      end
   endtask

   task automatic t_six_step();
      next_cycle(); set_gl(1, 1, 16'hA501); #1;
      chk("R5 GL sent without BE", gl_grant, 1);
      chk("R5 budget kept", out_data, 16'hA501);
      next_cycle(); set_gl(1, 1, 16'hA501); set_be(0, 1, 1); #1;
      chk("R2 BE beats GL", be_grant, 4'b0001);
      next_cycle(); set_gl(1, 1, 16'hA501); set_be(0, 1, 1); #1;
      chk("R4 critical GL", gl_grant, 1);
      chk("R4 BE blocked", be_grant, 0);
      chk("R3 budget decremented", out_data[7:0], 0);
      chk("R6 upper header kept", out_data[15:8], 8'hA5);
      next_cycle(); set_be(0, 1, 1); #1;
      chk("R2 BE alone", be_grant, 4'b0001);
      next_cycle(); set_gl(1, 1, 16'hA501); set_be(0, 1, 1); #1;
      chk("R11 fresh budget BE wins", be_grant, 4'b0001);
      next_cycle(); set_gl(1, 1, 16'hA501); #1;
      chk("R5 GL sent", gl_grant, 1);
      chk("R3 forwarded budget", out_data, 16'hA500);
   endtask

   task automatic t_stall();
      for (int c = 0; c < 2; c++) begin
         next_cycle(); out_ready = 0; set_gl(1, 1, 16'hA501); set_be(0, 1, 1); #1;
         chk("R3 no charge on stall", gl_grant, 0);
         chk("R2 BE offered", be_grant, 4'b0001);
      end
      next_cycle(); out_ready = 1; set_gl(1, 1, 16'hA501); set_be(0, 1, 1); #1;
      chk("R2 BE after stall", be_grant, 4'b0001);
      next_cycle(); set_gl(1, 1, 16'hA501); set_be(0, 1, 1); #1;
      chk("R3 one charge only", gl_grant, 1);
      chk("R3 budget zero", out_data, 16'hA500);
   endtask

   task automatic t_wormhole();
      next_cycle(); set_gl(1, 0, 16'hA503); set_be(2, 1, 0); #1;
      chk("R2 BE head", be_grant, 4'b0100);
      for (int c = 0; c < 2; c++) begin
         next_cycle(); set_gl(1, 0, 16'hA503); set_be(2, 0, 0); set_be(1, 1, 1); #1;
         chk("R8 BE body locked", be_grant, 4'b0100);
      end
      next_cycle(); set_gl(1, 0, 16'hA503); set_be(2, 0, 1); set_be(1, 1, 1); #1;
      chk("R8 BE tail locked", be_grant, 4'b0100);
      chk("R8 GL held off", gl_grant, 0);
      next_cycle(); set_gl(1, 0, 16'hA503); set_be(1, 1, 1); #1;
      chk("R7 saturated GL wins", gl_grant, 1);
      chk("R7 budget zero", out_data, 16'hA500);
      next_cycle(); set_gl(0, 1, 16'hC37E); set_be(1, 1, 1); #1;
      chk("R8 GL body locked", gl_grant, 1);
      chk("R6 body unchanged", out_data, 16'hC37E);
      next_cycle(); set_be(1, 1, 1); #1;
      chk("R9 BE1 after GL", be_grant, 4'b0010);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      rst_n = 0;
      out_ready = 1;
      clr_in();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      t_reset();
      t_round_robin();
      t_six_step();
      t_stall();
      t_wormhole();
      next_cycle();
      summary();
   end

endmodule